// File: doc/BRIEF.md
# Selectable Flow-Through / Registered Read-Data Output Stage

This block is the read-data output path of a synchronous burst memory. Each clock edge registers a command (deselect, read, write or hold) into a first stage. The array supplies read data during the cycle after that edge. A static mode input then picks how the data reaches the pins. In flow-through mode the array data goes straight to the output bus in that same cycle. In registered mode a rising-edge output register captures the data and the command state, so the data appears one cycle later.

Deselects move through the stages in the same way as reads. In registered mode a deselect leaves the drivers on for one more full cycle, and they switch off only after the second rising edge that follows it. This is the dual-cycle-deselect behaviour. An active-low output enable gates the drive-enable output combinationally. It can switch the drivers off at any instant, but it can switch them on only in a cycle that carries read data. A read issued while the output enable is high (a dummy read) moves through the stages normally but drives nothing.

Both stages are small state machines with three states: `SLOT_OFF`, `SLOT_RD` and `SLOT_WR`. In the command stage, code 00 (deselect) moves to `SLOT_OFF`, 01 (read) moves to `SLOT_RD` and 10 (write) moves to `SLOT_WR`, from any state. Code 11 (hold) keeps the current state, which models a suspended burst. The output register stage moves to whatever state the command stage held at the edge. The mode input should be tied high unless flow-through is wanted, because registered mode is the default configuration.

Top module: `burst_rdout_stage`

## Requirements
- R1: While reset is asserted, and after reset until a read command has been registered, `drive_en_o` is 0. Reset sets both stages to `SLOT_OFF`.
- R2: With `bypass_n`=0 (flow-through), a read command registered at edge k gives `drive_en_o`=1 (when `oe_n`=0) and `dq_o` equal to the current `rd_data_i` throughout the cycle that follows edge k.
- R3: With `bypass_n`=1 (registered), a read command registered at edge k gives `drive_en_o`=1 (when `oe_n`=0) during the cycle after edge k+1. In that cycle `dq_o` equals the `rd_data_i` value present in the cycle between edges k and k+1.
- R4: With `bypass_n`=1, a deselect command registered at edge k leaves `drive_en_o` as set by the previous command during the cycle after edge k. `drive_en_o` is 0 from edge k+1 onward.
- R5: Whenever the stage selected by the mode holds a write, `drive_en_o` is 0, for any value of `oe_n`.
- R6: `oe_n`=1 forces `drive_en_o` to 0 at once, with no clock edge needed.
- R7: Lowering `oe_n` raises `drive_en_o` without a clock edge, but only when the selected stage holds a read. A read registered while `oe_n` was high still advances through the stages.
- R8: Command encoding on `cmd_i` is 00 deselect, 01 read, 10 write and 11 hold. Hold keeps the previous state of the command stage, so a hold issued right after reset counts as a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass_n | input | 1 | Static mode: 0 flow-through, 1 registered (default) |
| oe_n | input | 1 | Asynchronous active-low output enable |
| cmd_i | input | 2 | Command registered at each rising edge |
| rd_data_i | input | DATA_W | Array read data for the command registered at the last edge |
| dq_o | output | DATA_W | Output data bus value |
| drive_en_o | output | 1 | Output driver enable |

## Verification
A wrong state in the command stage shows at the ports within one cycle in flow-through mode and within two cycles in registered mode. It appears as drive enable on the wrong cycle, or as data from the wrong cycle. A stuck or mis-staged output register is exposed at the first deselect that follows a read. The drivers then turn off one edge too early or one edge too late, and this is visible on the very next sample. Hold sequences mistracked by the command stage give a wrong enable after at most two edges.

// File: rtl/burst_rdout_pkg.sv
package burst_rdout_pkg;

    typedef enum logic [1:0] {
        CMD_DESEL = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_HOLD  = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        SLOT_OFF = 2'b00,
        SLOT_RD  = 2'b01,
        SLOT_WR  = 2'b10
    } slot_e;

endpackage

// File: rtl/burst_cmd_stage.sv
module burst_cmd_stage
    import burst_rdout_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cmd_i,
    output slot_e      slot_o
);

    slot_e state_q;
    slot_e state_d;
    cmd_e  cmd;

    assign cmd = cmd_e'(cmd_i);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (cmd)
            CMD_DESEL: state_d = SLOT_OFF;
            CMD_READ:  state_d = SLOT_RD;
            CMD_WRITE: state_d = SLOT_WR;
            CMD_HOLD:  state_d = state_q;
            default:   state_d = SLOT_OFF;
        endcase
    end

    // outputs
    always_comb begin
        slot_o = state_q;
    end

endmodule

// File: rtl/burst_out_reg.sv
module burst_out_reg
    import burst_rdout_pkg::*;
#(
    parameter int LANE_W  = 9,
    parameter int N_LANES = 4,
    localparam int DATA_W = LANE_W * N_LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_e             slot_i,
    input  logic [DATA_W-1:0] data_i,
    output slot_e             slot_o,
    output logic [DATA_W-1:0] data_o
);

    slot_e state_q;

    // state register: follows the command stage one edge later
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_OFF;
        end else begin
            unique case (slot_i)
                SLOT_OFF: state_q <= SLOT_OFF;
                SLOT_RD:  state_q <= SLOT_RD;
                SLOT_WR:  state_q <= SLOT_WR;
                default:  state_q <= SLOT_OFF;
            endcase
        end
    end

    // per-lane data capture
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else begin
                lane_q <= data_i[g*LANE_W +: LANE_W];
            end
        end
        assign data_o[g*LANE_W +: LANE_W] = lane_q;
    end

    always_comb begin
        slot_o = state_q;
    end

endmodule

// File: rtl/burst_drive_ctl.sv
module burst_drive_ctl
    import burst_rdout_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              bypass_n,
    input  logic              oe_n,
    input  slot_e             flow_slot_i,
    input  logic [DATA_W-1:0] flow_data_i,
    input  slot_e             reg_slot_i,
    input  logic [DATA_W-1:0] reg_data_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              drive_en_o
);

    slot_e sel_slot;

    always_comb begin
        sel_slot = bypass_n ? reg_slot_i : flow_slot_i;
        dq_o     = bypass_n ? reg_data_i : flow_data_i;
    end

    always_comb begin
        unique case (sel_slot)
            SLOT_RD:  drive_en_o = !oe_n;
            SLOT_WR:  drive_en_o = 1'b0;
            SLOT_OFF: drive_en_o = 1'b0;
            default:  drive_en_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/burst_rdout_stage.sv
module burst_rdout_stage
    import burst_rdout_pkg::*;
#(
    parameter int LANE_W  = 9,
    parameter int N_LANES = 4,
    localparam int DATA_W = LANE_W * N_LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass_n,
    input  logic              oe_n,
    input  logic [1:0]        cmd_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              drive_en_o
);

    slot_e             s1_slot;
    slot_e             s2_slot;
    logic [DATA_W-1:0] s2_data;

    burst_cmd_stage u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_i  (cmd_i),
        .slot_o (s1_slot)
    );

    burst_out_reg #(
        .LANE_W  (LANE_W),
        .N_LANES (N_LANES)
    ) u_oreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_i (s1_slot),
        .data_i (rd_data_i),
        .slot_o (s2_slot),
        .data_o (s2_data)
    );

    burst_drive_ctl #(
        .DATA_W (DATA_W)
    ) u_drv (
        .bypass_n    (bypass_n),
        .oe_n        (oe_n),
        .flow_slot_i (s1_slot),
        .flow_data_i (rd_data_i),
        .reg_slot_i  (s2_slot),
        .reg_data_i  (s2_data),
        .dq_o        (dq_o),
        .drive_en_o  (drive_en_o)
    );

endmodule

// File: rtl/burst_rdout_chk.sv
module burst_rdout_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bypass_n,
    input logic              oe_n,
    input logic [1:0]        cmd_i,
    input logic [DATA_W-1:0] rd_data_i,
    input logic [DATA_W-1:0] dq_o,
    input logic              drive_en_o
);

    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    AST_OE_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !drive_en_o); // R6

    AST_FLOW_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && !bypass_n && $past(cmd_i) == 2'b01 && !oe_n)
        |-> (drive_en_o && dq_o == rd_data_i)); // R2

    AST_PIPE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && bypass_n && $past(cmd_i, 2) == 2'b01 && !oe_n)
        |-> (drive_en_o && dq_o == $past(rd_data_i))); // R3

    AST_PIPE_DESEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && bypass_n && $past(cmd_i, 2) == 2'b00)
        |-> !drive_en_o); // R4

    AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && bypass_n && $past(cmd_i, 2) == 2'b10)
        |-> !drive_en_o); // R5

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd0) |-> !drive_en_o); // R1

endmodule

bind burst_rdout_stage burst_rdout_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bypass_n   (bypass_n),
    .oe_n       (oe_n),
    .cmd_i      (cmd_i),
    .rd_data_i  (rd_data_i),
    .dq_o       (dq_o),
    .drive_en_o (drive_en_o)
);

// File: tb/tb_burst_rdout_stage.sv
`timescale 1ns/1ps
module tb_burst_rdout_stage;

    localparam int LANE_W  = 9;
    localparam int N_LANES = 4;
    localparam int DW      = LANE_W * N_LANES;

    // model kinds: 0 off, 1 read, 2 write
    localparam int K_OFF = 0;
    localparam int K_RD  = 1;
    localparam int K_WR  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bypass_n = 1'b1;
    logic          oe_n = 1'b0;
    logic [1:0]    cmd_i = 2'b00;
    logic [DW-1:0] rd_data_i = '0;
    logic [DW-1:0] dq_o;
    logic          drive_en_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    int            kind1;
    int            kind2;
    logic [DW-1:0] data2;

    always #5 clk = ~clk;

    burst_rdout_stage #(.LANE_W(LANE_W), .N_LANES(N_LANES)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bypass_n   (bypass_n),
        .oe_n       (oe_n),
        .cmd_i      (cmd_i),
        .rd_data_i  (rd_data_i),
        .dq_o       (dq_o),
        .drive_en_o (drive_en_o)
    );

    function automatic logic [DW-1:0] pat(input int n);
        logic [DW-1:0] v;
        v = DW'(n) * DW'(36'h9E3779B1) ^ DW'(n << 7) ^ DW'(36'h5A5A5);
        return v;
    endfunction

    function automatic int next_kind(input int k, input logic [1:0] c);
        case (c)
            2'b00:   return K_OFF;
            2'b01:   return K_RD;
            2'b10:   return K_WR;
            default: return k; // hold, R8
        endcase
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cyc=%0d actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        rst_n    = 1'b0;
        bypass_n = mode;
        cmd_i    = 2'b01;
        oe_n     = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        check("R1", DW'(drive_en_o), DW'(0));
        cmd_i = 2'b00;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        kind1 = K_OFF;
        kind2 = K_OFF;
        data2 = rd_data_i;
        #2;
        check("R1", DW'(drive_en_o), DW'(0));
    endtask

    task automatic step(input logic [1:0] c, input logic oe, input bit pulse_oe);
        int            sel;
        bit            en;
        logic [DW-1:0] ed;
        string         tag;
        @(posedge clk);
        kind2 = kind1;
        data2 = rd_data_i;
        kind1 = next_kind(kind1, cmd_i);
        #1;
        cmd_i     = c;
        oe_n      = oe;
        rd_data_i = pat(cyc);
        cyc++;
        @(negedge clk);
        sel = bypass_n ? kind2 : kind1;
        ed  = bypass_n ? data2 : rd_data_i;
        en  = (sel == K_RD) && !oe;
        if (sel == K_WR)                         tag = "R5";
        else if (bypass_n && kind2 == K_OFF)     tag = "R4";
        else if (sel == K_RD && oe)              tag = "R6";
        else if (sel == K_RD && !bypass_n)       tag = "R2";
        else if (sel == K_RD)                    tag = "R3";
        else                                     tag = "R8";
        check(tag, DW'(drive_en_o), DW'(en));
        if (en) check(tag, dq_o, ed);
        if (pulse_oe && sel == K_RD) begin
            oe_n = 1'b1;
            #1;
            check("R6", DW'(drive_en_o), DW'(0));
            oe_n = 1'b0;
            #1;
            check("R7", DW'(drive_en_o), DW'(1));
            check("R7", dq_o, ed);
            oe_n = oe;
        end
    endtask

    initial begin
        for (int m = 0; m < 2; m++) begin
            do_reset(m[0]);
            // hold right after reset acts as deselect, R8
            step(2'b11, 1'b0, 1'b0);
            step(2'b11, 1'b0, 1'b0);
            step(2'b00, 1'b0, 1'b0);
            // sweep of all three-command sequences
            for (int n = 0; n < 192; n++) begin
                logic [1:0] c;
                logic       o;
                c = 2'((n / 3) >> (2 * (2 - (n % 3))));
                o = ((n * 5) % 11) == 0;
                step(c, o, (n % 4) == 1);
            end
            // dummy read then oe low on its data cycle, R7
            step(2'b01, 1'b1, 1'b0);
            step(2'b00, 1'b0, 1'b1);
            step(2'b00, 1'b0, 1'b0);
            step(2'b00, 1'b0, 1'b0);
            // read burst, deselect, turn-off edge, R4
            step(2'b01, 1'b0, 1'b0);
            step(2'b11, 1'b0, 1'b0);
            step(2'b00, 1'b0, 1'b0);
            step(2'b00, 1'b0, 1'b0);
            step(2'b00, 1'b0, 1'b0);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule